// File: doc/BRIEF.md
# Display Plane Pixel Format Unpacker

This block sits in a display plane, between the memory fetch logic and the colour pipeline. Memory words of 32 bits arrive on a valid/ready input. The block takes each word apart into pixels and sends one pixel per cycle on a valid/ready output. A colour pixel is given as 8-bit red, green, blue and alpha. An indexed pixel is given as an 8-bit palette index with a flag set, so that a palette stage further down can look it up.

A control word carries two things: an enable bit and a 4-bit pixel format code. The code decides how many pixels come from each word. It also decides how the bits of each pixel are split into channels. Channels narrower than 8 bits are widened by replicating their top bits. When the code is not a defined format, the block emits black pixels and raises an error flag that stays set until reset.

Top module: `pix_unpacker`

## Requirements
- R1: When `ctrl_word[31]` is 0, `pix_valid` and `word_ready` are both 0. No word is accepted and no pixel is presented, and any word already held stays held until the plane is enabled again.
- R2: The format code is `ctrl_word[29:26]`. Code 2 gives 4 pixels per word, codes 4 and 5 give 2 pixels per word, and codes 6 and 7 give 1 pixel per word. Pixels leave in order from the least significant bits of the word to the most significant.
- R3: Code 2 is indexed. The pixel byte appears on `pix_index` and `pix_is_index` is 1; red, green and blue are 0 and alpha is 0xFF. In all other codes `pix_is_index` is 0 and `pix_index` is 0.
- R4: Code 4 is a 16-bit pixel with red in bits 14:10, green in bits 9:5 and blue in bits 4:0; bit 15 is ignored. Each 5-bit channel c becomes {c, c[4:2]}, and alpha is 0xFF.
- R5: Code 5 is a 16-bit pixel with red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Red and blue are widened as in R4, green g becomes {g, g[5:4]}, and alpha is 0xFF.
- R6: Code 6 takes red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 are ignored and alpha is 0xFF.
- R7: Code 7 uses the same colour layout as R6 and takes alpha from bits 31:24.
- R8: Any other code is reserved. Each word gives one pixel with red, green and blue 0 and alpha 0xFF. `fmt_err` becomes 1 when such a word is accepted and stays 1 until reset.
- R9: The format code is latched when a word is accepted. If the live code differs from the latched code while a word is held and the plane is enabled, `pix_valid` drops in that same cycle and the rest of the word is discarded at the next edge. The next word is then decoded with the new code.
- R10: While `pix_valid` is 1, `pix_ready` is 0 and the control word is unchanged, the pixel stays presented and unchanged in the next cycle.
- R11: `word_ready` is 1 only when the plane is enabled and either no word is held or the held word's last pixel is being accepted in that cycle. With `pix_ready` held at 1 and words offered back to back, one pixel is accepted every cycle with no gap between words.
- R12: After reset, `pix_valid` is 0, `fmt_err` is 0 and, with the plane enabled, `word_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Plane control: bit 31 enable, bits 29:26 format code |
| word_data | input | 32 | Fetched surface word |
| word_valid | input | 1 | `word_data` holds a word |
| word_ready | output | 1 | Block accepts the offered word this cycle |
| pix_valid | output | 1 | A pixel is presented |
| pix_ready | input | 1 | Downstream accepts the pixel this cycle |
| pix_red | output | 8 | Red channel |
| pix_green | output | 8 | Green channel |
| pix_blue | output | 8 | Blue channel |
| pix_alpha | output | 8 | Alpha channel |
| pix_index | output | 8 | Palette index (indexed format only) |
| pix_is_index | output | 1 | Pixel is a palette index |
| fmt_err | output | 1 | Sticky flag: a word with a reserved format was accepted |

## Verification
A word accepted at a clock edge gives its first pixel on `pix_valid` in the cycle right after that edge. Each later pixel of the same word follows one edge after its predecessor is accepted. `word_ready` and the drop of `pix_valid` on a format change are combinational, so both show in the same cycle as the condition that causes them, and `fmt_err` shows in the cycle the reserved word's pixel first appears. The bench changes inputs shortly after a rising edge and reads outputs at the falling edge, so every value it reads has settled for the cycle in which it counts. A scoreboard predicts each pixel, and the bench pushes the prediction before the pixel can be taken.

// File: rtl/pixu_pkg.sv
package pixu_pkg;

  localparam int CHAN_W = 8;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_IDX8   = 4'd2;
  localparam logic [CODE_W-1:0] CODE_RGB15  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_RGB16  = 4'd5;
  localparam logic [CODE_W-1:0] CODE_XRGB32 = 4'd6;
  localparam logic [CODE_W-1:0] CODE_ARGB32 = 4'd7;

  typedef enum logic [2:0] {
    KIND_IDX8,
    KIND_RGB15,
    KIND_RGB16,
    KIND_XRGB32,
    KIND_ARGB32,
    KIND_RSVD
  } pix_kind_e;

  typedef struct packed {
    logic              is_index;
    logic [CHAN_W-1:0] index;
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] green;
    logic [CHAN_W-1:0] blue;
    logic [CHAN_W-1:0] alpha;
  } pix_t;

  function automatic pix_kind_e kind_of(input logic [CODE_W-1:0] code);
    pix_kind_e k;
    case (code)
      CODE_IDX8:   k = KIND_IDX8;
      CODE_RGB15:  k = KIND_RGB15;
      CODE_RGB16:  k = KIND_RGB16;
      CODE_XRGB32: k = KIND_XRGB32;
      CODE_ARGB32: k = KIND_ARGB32;
      default:     k = KIND_RSVD;
    endcase
    return k;
  endfunction

  function automatic int unsigned bits_per_pixel(input pix_kind_e k);
    int unsigned b;
    case (k)
      KIND_IDX8:              b = 8;
      KIND_RGB15, KIND_RGB16: b = 16;
      default:                b = 32;
    endcase
    return b;
  endfunction

  function automatic logic [CHAN_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [CHAN_W-1:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic pix_t pix_indexed(input logic [7:0] b);
    pix_t p;
    p          = '0;
    p.is_index = 1'b1;
    p.index    = b;
    p.alpha    = '1;
    return p;
  endfunction

  function automatic pix_t pix_rgb15(input logic [15:0] h);
    pix_t p;
    p       = '0;
    p.red   = widen5(h[14:10]);
    p.green = widen5(h[9:5]);
    p.blue  = widen5(h[4:0]);
    p.alpha = '1;
    return p;
  endfunction

  function automatic pix_t pix_rgb16(input logic [15:0] h);
    pix_t p;
    p       = '0;
    p.red   = widen5(h[15:11]);
    p.green = widen6(h[10:5]);
    p.blue  = widen5(h[4:0]);
    p.alpha = '1;
    return p;
  endfunction

  function automatic pix_t pix_rgb32(input logic [31:0] w, input logic keep_alpha);
    pix_t p;
    p       = '0;
    p.red   = w[23:16];
    p.green = w[15:8];
    p.blue  = w[7:0];
    p.alpha = keep_alpha ? w[31:24] : '1;
    return p;
  endfunction

  function automatic pix_t pix_black();
    pix_t p;
    p       = '0;
    p.alpha = '1;
    return p;
  endfunction

endpackage

// File: rtl/pixu_word_hold.sv
module pixu_word_hold
  import pixu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] live_code,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] word_q,
  output logic [CODE_W-1:0] code_q,
  output pix_kind_e         kind_q,
  output logic [LANE_W-1:0] lane_q,
  output logic              full_q,
  output logic              last_lane,
  output logic              take_evt,
  output logic              load_evt,
  output logic              drop_evt
);

  function automatic logic [LANE_W-1:0] final_lane(input pix_kind_e k);
    int unsigned n;
    n = WORD_W / bits_per_pixel(k);
    return LANE_W'(n - 1);
  endfunction

  logic code_moved;

  assign kind_q     = kind_of(code_q);
  assign last_lane  = (lane_q == final_lane(kind_q));
  assign code_moved = full_q && (live_code != code_q);
  assign drop_evt   = en && code_moved;
  assign out_valid  = en && full_q && !code_moved;
  assign take_evt   = out_valid && out_ready;
  assign in_ready   = en && !code_moved && (!full_q || (take_evt && last_lane));
  assign load_evt   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      lane_q <= '0;
      code_q <= '0;
      word_q <= '0;
    end else if (drop_evt) begin
      full_q <= 1'b0;
      lane_q <= '0;
    end else if (load_evt) begin
      full_q <= 1'b1;
      lane_q <= '0;
      code_q <= live_code;
      word_q <= in_data;
    end else if (take_evt) begin
      if (last_lane) begin
        full_q <= 1'b0;
        lane_q <= '0;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pixu_lane_sel.sv
module pixu_lane_sel #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [7:0]        byte_sel,
  output logic [15:0]       half_sel
);

  localparam int BYTE_LANES = WORD_W / 8;
  localparam int HALF_LANES = WORD_W / 16;
  localparam int HALF_IDX_W = (HALF_LANES > 1) ? $clog2(HALF_LANES) : 1;

  logic [7:0]  bytes [BYTE_LANES];
  logic [15:0] halves[HALF_LANES];

  for (genvar gb = 0; gb < BYTE_LANES; gb++) begin : g_byte
    assign bytes[gb] = word[gb*8 +: 8];
  end

  for (genvar gh = 0; gh < HALF_LANES; gh++) begin : g_half
    assign halves[gh] = word[gh*16 +: 16];
  end

  assign byte_sel = bytes[lane];
  assign half_sel = halves[lane[HALF_IDX_W-1:0]];

endmodule

// File: rtl/pixu_decode.sv
module pixu_decode
  import pixu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  pix_kind_e         kind,
  input  logic [7:0]        byte_sel,
  input  logic [15:0]       half_sel,
  input  logic [WORD_W-1:0] word,
  output pix_t              pix
);

  always_comb begin
    case (kind)
      KIND_IDX8:   pix = pix_indexed(byte_sel);
      KIND_RGB15:  pix = pix_rgb15(half_sel);
      KIND_RGB16:  pix = pix_rgb16(half_sel);
      KIND_XRGB32: pix = pix_rgb32(word[31:0], 1'b0);
      KIND_ARGB32: pix = pix_rgb32(word[31:0], 1'b1);
      default:     pix = pix_black();
    endcase
  end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pixu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int EN_BIT  = 31,
  parameter int FMT_LSB = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [7:0]        pix_red,
  output logic [7:0]        pix_green,
  output logic [7:0]        pix_blue,
  output logic [7:0]        pix_alpha,
  output logic [7:0]        pix_index,
  output logic              pix_is_index,
  output logic              fmt_err
);

  localparam int LANE_W = $clog2(WORD_W / 8);

  logic              plane_en;
  logic [CODE_W-1:0] live_code;
  logic [WORD_W-1:0] hold_word;
  logic [CODE_W-1:0] hold_code;
  pix_kind_e         hold_kind;
  logic [LANE_W-1:0] hold_lane;
  logic              hold_full;
  logic              hold_last;
  logic              take_evt;
  logic              load_evt;
  logic              drop_evt;
  logic [7:0]        byte_sel;
  logic [15:0]       half_sel;
  pix_t              pix;
  logic              err_q;

  assign plane_en  = ctrl_word[EN_BIT];
  assign live_code = ctrl_word[FMT_LSB +: CODE_W];

  pixu_word_hold #(
    .WORD_W (WORD_W),
    .LANE_W (LANE_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (plane_en),
    .live_code (live_code),
    .in_valid  (word_valid),
    .in_data   (word_data),
    .in_ready  (word_ready),
    .out_ready (pix_ready),
    .out_valid (pix_valid),
    .word_q    (hold_word),
    .code_q    (hold_code),
    .kind_q    (hold_kind),
    .lane_q    (hold_lane),
    .full_q    (hold_full),
    .last_lane (hold_last),
    .take_evt  (take_evt),
    .load_evt  (load_evt),
    .drop_evt  (drop_evt)
  );

  pixu_lane_sel #(
    .WORD_W (WORD_W),
    .LANE_W (LANE_W)
  ) u_sel (
    .word     (hold_word),
    .lane     (hold_lane),
    .byte_sel (byte_sel),
    .half_sel (half_sel)
  );

  pixu_decode #(
    .WORD_W (WORD_W)
  ) u_dec (
    .kind     (hold_kind),
    .byte_sel (byte_sel),
    .half_sel (half_sel),
    .word     (hold_word),
    .pix      (pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (load_evt && (kind_of(live_code) == KIND_RSVD)) begin
      err_q <= 1'b1;
    end
  end

  assign fmt_err      = err_q;
  assign pix_red      = pix.red;
  assign pix_green    = pix.green;
  assign pix_blue     = pix.blue;
  assign pix_alpha    = pix.alpha;
  assign pix_index    = pix.index;
  assign pix_is_index = pix.is_index;

endmodule

// File: rtl/pix_unpacker_chk.sv
module pix_unpacker_chk
  import pixu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       ctrl_word,
  input logic              word_ready,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [7:0]        pix_red,
  input logic [7:0]        pix_green,
  input logic [7:0]        pix_blue,
  input logic [7:0]        pix_alpha,
  input logic [7:0]        pix_index,
  input logic              pix_is_index,
  input logic              fmt_err,
  input logic              hold_full,
  input logic              hold_last,
  input logic [CODE_W-1:0] hold_code,
  input pix_kind_e         hold_kind
);

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[31] |-> (!pix_valid && !word_ready));

  assert_index_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_is_index == (hold_kind == KIND_IDX8)));

  assert_alpha_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hold_kind != KIND_ARGB32) |-> (pix_alpha == 8'hFF));

  assert_rsvd_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hold_kind == KIND_RSVD) |->
      (pix_red == 8'h00 && pix_green == 8'h00 && pix_blue == 8'h00 && fmt_err));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  assert_code_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[31] && hold_full && ctrl_word[29:26] != hold_code) |->
      (!pix_valid && !word_ready));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=>
      (!$stable(ctrl_word) ||
       (pix_valid && $stable(pix_red) && $stable(pix_green) && $stable(pix_blue) &&
        $stable(pix_alpha) && $stable(pix_index) && $stable(pix_is_index))));

  assert_ready_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && hold_full) |-> (pix_valid && pix_ready && hold_last));

endmodule

bind pix_unpacker pix_unpacker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_word    (ctrl_word),
  .word_ready   (word_ready),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_red      (pix_red),
  .pix_green    (pix_green),
  .pix_blue     (pix_blue),
  .pix_alpha    (pix_alpha),
  .pix_index    (pix_index),
  .pix_is_index (pix_is_index),
  .fmt_err      (fmt_err),
  .hold_full    (hold_full),
  .hold_last    (hold_last),
  .hold_code    (hold_code),
  .hold_kind    (hold_kind)
);

// File: tb/pix_unpacker_test.sv
module pix_unpacker_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic [31:0] word_data;
  logic        word_valid;
  logic        word_ready;
  logic        pix_valid;
  logic        pix_ready;
  logic [7:0]  pix_red, pix_green, pix_blue, pix_alpha, pix_index;
  logic        pix_is_index;
  logic        fmt_err;

  pix_unpacker uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_red(pix_red), .pix_green(pix_green),
    .pix_blue(pix_blue), .pix_alpha(pix_alpha), .pix_index(pix_index),
    .pix_is_index(pix_is_index), .fmt_err(fmt_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  code;
    logic [40:0] pix;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   auto_rdy = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  int   acc_n = 0;
  int   acc_first = 0;
  int   acc_last = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input logic [3:0] code);
    return (32'(en) << 31) | (32'(code) << 26);
  endfunction

  function automatic int pix_count(input logic [3:0] code);
    if (code == 4'd2) return 4;
    if (code == 4'd4 || code == 4'd5) return 2;
    return 1;
  endfunction

  function automatic logic [7:0] grow(input int v, input int bits);
    int r;
    r = (v << (8 - bits)) | (v >> (2 * bits - 8));
    return r[7:0];
  endfunction

  // pixel packed as {is_index, index, red, green, blue, alpha}
  function automatic logic [40:0] model(input logic [3:0] code, input logic [31:0] w, input int lane);
    int h;
    int b;
    logic [7:0] r, g, bl, a, ix;
    logic isx;
    r = 0; g = 0; bl = 0; a = 8'hFF; ix = 0; isx = 0;
    b = (w >> (lane * 8)) & 255;
    h = (w >> (lane * 16)) & 65535;
    case (code)
      4'd2: begin isx = 1; ix = b[7:0]; end
      4'd4: begin r = grow((h >> 10) & 31, 5); g = grow((h >> 5) & 31, 5); bl = grow(h & 31, 5); end
      4'd5: begin r = grow((h >> 11) & 31, 5); g = grow((h >> 5) & 63, 6); bl = grow(h & 31, 5); end
      4'd6: begin r = w[23:16]; g = w[15:8]; bl = w[7:0]; end
      4'd7: begin r = w[23:16]; g = w[15:8]; bl = w[7:0]; a = w[31:24]; end
      default: ;
    endcase
    return {isx, ix, r, g, bl, a};
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    case (code)
      4'd2: return "R2 R3";
      4'd4: return "R2 R4";
      4'd5: return "R2 R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // ready pattern, changed shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (auto_rdy) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pix_ready = lfsr[0] | lfsr[3];
    end
  end

  // scoreboard monitor, samples at the falling edge
  logic [40:0] prev_pix;
  logic [31:0] prev_ctrl;
  bit          prev_stall = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [40:0] act;
      act = {pix_is_index, pix_index, pix_red, pix_green, pix_blue, pix_alpha};
      if (prev_stall && ctrl_word == prev_ctrl && ctrl_word[31])
        chk(pix_valid && act == prev_pix, "R10", "stalled pixel held", {pix_valid, act}, {1'b1, prev_pix});
      if (pix_valid && pix_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected pixel", act, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(act == e.pix, tag_of(e.code), "pixel", act, e.pix);
        end
        if (acc_n == 0) acc_first = cyc;
        acc_last = cyc;
        acc_n++;
      end
      prev_stall = pix_valid && !pix_ready;
      prev_pix   = act;
      prev_ctrl  = ctrl_word;
    end
  end

  // called just after a rising edge; returns just after the accepting edge
  task automatic send_word(input logic [3:0] code, input logic [31:0] w, input int keep);
    int n;
    n = (keep < 0) ? pix_count(code) : keep;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.code = code;
      e.pix  = model(code, w, i);
      q.push_back(e);
    end
    word_data  = w;
    word_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (word_ready) break;
    end
    @(posedge clk);
    #1;
    word_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard drained", 64'(q.size()), 0);
    @(posedge clk);
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_word = mk_ctrl(1, 4'd2); word_data = '0;
    word_valid = 1'b0; pix_ready = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_valid, "R12", "pix_valid after reset", 64'(pix_valid), 0);
    chk(!fmt_err, "R12", "fmt_err after reset", 64'(fmt_err), 0);
    chk(word_ready, "R12", "word_ready after reset", 64'(word_ready), 1);
    step();

    // R1: disabled plane takes nothing
    ctrl_word = mk_ctrl(0, 4'd7);
    word_data = 32'hA1B2C3D4; word_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!word_ready && !pix_valid, "R1", "disabled idle", {word_ready, pix_valid}, 0);
    end
    step();
    word_valid = 1'b0;
    ctrl_word = mk_ctrl(1, 4'd7);
    pix_ready = 1'b1;
    send_word(4'd7, 32'hA1B2C3D4, -1);
    drain();

    // R1: held word is hidden while disabled, then resumes
    pix_ready = 1'b0;
    ctrl_word = mk_ctrl(1, 4'd6);
    send_word(4'd6, 32'h11223344, -1);
    @(negedge clk);
    chk(pix_valid, "R1", "held pixel shown", 64'(pix_valid), 1);
    step();
    ctrl_word = mk_ctrl(0, 4'd6);
    @(negedge clk);
    chk(!pix_valid, "R1", "held pixel hidden", 64'(pix_valid), 0);
    step();
    ctrl_word = mk_ctrl(1, 4'd6);
    pix_ready = 1'b1;
    drain();

    // every format under an irregular ready pattern
    auto_rdy = 1'b1;
    ctrl_word = mk_ctrl(1, 4'd2);
    send_word(4'd2, 32'h04030201, -1);
    send_word(4'd2, 32'h80FF7F00, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd4);
    send_word(4'd4, 32'h03E07C00, -1);
    send_word(4'd4, 32'h5555801F, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd5);
    send_word(4'd5, 32'h07E0F800, -1);
    send_word(4'd5, 32'h1234001F, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd6);
    send_word(4'd6, 32'hFF123456, -1);
    send_word(4'd6, 32'h00ABCDEF, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd7);
    send_word(4'd7, 32'h80A0B0C0, -1);
    send_word(4'd7, 32'h00010203, -1);
    drain();
    auto_rdy = 1'b0;

    // R9: format change mid-word drops the rest of it; R11 ready gating
    pix_ready = 1'b0;
    ctrl_word = mk_ctrl(1, 4'd2);
    send_word(4'd2, 32'hDDCCBBAA, 1);
    @(negedge clk);
    chk(pix_valid && !word_ready, "R11", "ready low mid-word", {pix_valid, word_ready}, 2'b10);
    step();
    pix_ready = 1'b1;
    step();
    pix_ready = 1'b0;
    ctrl_word = mk_ctrl(1, 4'd7);
    @(negedge clk);
    chk(!pix_valid && !word_ready, "R9", "drop cycle", {pix_valid, word_ready}, 0);
    step();
    @(negedge clk);
    chk(word_ready && !pix_valid, "R9", "empty after drop", {word_ready, pix_valid}, 2'b10);
    step();
    pix_ready = 1'b1;
    send_word(4'd7, 32'h7F6E5D4C, -1);
    drain();

    // R11: back-to-back words, one pixel per cycle
    ctrl_word = mk_ctrl(1, 4'd2);
    pix_ready = 1'b1;
    acc_n = 0;
    send_word(4'd2, 32'h13121110, -1);
    send_word(4'd2, 32'h17161514, -1);
    drain();
    chk(acc_n == 8, "R11", "pixel count", 64'(acc_n), 8);
    chk(acc_last - acc_first == 7, "R11", "span of 8 pixels", 64'(acc_last - acc_first), 7);

    // R8: reserved codes
    ctrl_word = mk_ctrl(1, 4'd0);
    acc_n = 0;
    send_word(4'd0, 32'hFFFFFFFF, -1);
    drain();
    chk(acc_n == 1, "R8", "one pixel per reserved word", 64'(acc_n), 1);
    chk(fmt_err, "R8", "error raised", 64'(fmt_err), 1);
    ctrl_word = mk_ctrl(1, 4'd15);
    send_word(4'd15, 32'h12345678, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd3);
    send_word(4'd3, 32'h9ABCDEF0, -1);
    drain();
    ctrl_word = mk_ctrl(1, 4'd6);
    send_word(4'd6, 32'h00C0FFEE, -1);
    drain();
    @(negedge clk);
    chk(fmt_err, "R8", "error sticky", 64'(fmt_err), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule